// File: doc/BRIEF.md
# Receive Trail Trace Extractor

This block sits behind an E3 receive framer and assembles a 16-byte trail access point identifier from the single trace byte that each frame carries. The framer presents each trace byte with a one-cycle valid strobe. The block can invert the byte and can then search the byte stream for the 16-byte multiframe. A byte whose most significant bit is 1 opens a multiframe. Captured multiframes are held back until the same identifier has arrived several times in a row. Only then does the identifier replace the accepted copy that software reads.

The accepted identifier is compared against an expected identifier that software writes one byte at a time. A mismatch flag reports any difference. An unstable flag reports a long run of multiframes in which each one differs from the previous one. While any line alarm is present, the accepted identifier is replaced by all ones and the alignment and history logic starts over. A registered read port returns one byte of the accepted identifier per address, either as stored or bit-reversed. This read port does not depend on the line strobe.

The alignment logic is a four-state machine. HUNT waits for a marker byte. PRESYNC checks that the next marker arrives exactly 16 bytes after the first one. SYNC is the locked state. SLIP is the locked state after one missing marker. The transitions are:

- hunt-to-presync on a marker.
- presync-to-sync on a correctly placed second marker.
- presync-to-hunt on any misplaced marker bit.
- sync-to-slip on a missing marker.
- slip-to-sync on a present marker.
- slip-to-hunt on a second missing marker.
- any-to-hunt on a line alarm.
- held in HUNT while alignment is disabled.

Top module: `rx_trace_extractor`

## Requirements
- R1: After reset, `rd_data` reads 8'hFF, the accepted identifier is all ones, the expected identifier is all zeros, `mismatch` is 1, and `unstable` and `in_sync` are 0.
- R2: With `inv_en` = 1, each line byte is complemented before marker detection and before it is stored. A stream of complemented bytes is therefore accepted as the original identifier.
- R3: With `sync_en` = 1, a marker is a processed byte with bit 7 = 1. The machine moves HUNT→PRESYNC on a marker. It moves PRESYNC→SYNC when the next marker arrives 16 bytes after the previous one, with 15 bytes of bit 7 = 0 between them. Any misplaced bit 7 in PRESYNC sends the machine back to HUNT. `in_sync` is 1 exactly in SYNC and SLIP.
- R4: In SYNC, a first byte with bit 7 = 0 moves the machine to SLIP, and `in_sync` stays 1. A present marker in SLIP returns it to SYNC. A second consecutive missing marker moves it to HUNT. A bit 7 = 1 in mid-multiframe positions is ignored while locked.
- R5: When locked, the byte at position k of a multiframe (marker = position 0) fills slot k. With `sync_en` = 0, bytes fill slots 0..15 cyclically, starting from reset or from the end of an alarm, and every 16th byte completes a multiframe.
- R6: A completed multiframe becomes the accepted identifier on the same edge that completes the third consecutive identical multiframe. Earlier or differing multiframes leave the accepted identifier unchanged.
- R7: `unstable` rises on the edge completing the 8th consecutive multiframe that differs from its predecessor. It falls when an identifier is accepted.
- R8: While any of `sig_loss`, `frame_loss` or `ais_alarm` is 1 at an edge, the line byte is ignored, the accepted identifier becomes all ones, the machine returns to HUNT at position 0, the repeat history is cleared and `unstable` falls.
- R9: `exp_wr` writes `exp_data` into expected byte `exp_addr` at the edge. `mismatch` is 1 whenever the accepted and expected identifiers differ in any bit.
- R10: `rd_data` returns, one edge after `rd_addr` is sampled, accepted byte `rd_addr`. With `lsb_first` = 1 the byte is bit-reversed, so output bit i is stored bit 7−i. The value is taken from the identifier as it was before that edge.
- R11: A cycle with `line_vld` = 0 has no effect on alignment, capture or history, whatever `line_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_byte | input | 8 | Trace byte from the framer |
| line_vld | input | 1 | One-cycle strobe qualifying `line_byte` |
| sig_loss | input | 1 | Loss-of-signal alarm |
| frame_loss | input | 1 | Loss-of-frame alarm |
| ais_alarm | input | 1 | Alarm-indication-signal alarm |
| sync_en | input | 1 | Enable multiframe alignment search |
| inv_en | input | 1 | Complement each line byte |
| lsb_first | input | 1 | Present read bytes bit-reversed |
| exp_wr | input | 1 | Write strobe for the expected identifier |
| exp_addr | input | 4 | Expected identifier byte index |
| exp_data | input | 8 | Expected identifier byte value |
| rd_addr | input | 4 | Accepted identifier byte index to read |
| rd_data | output | 8 | Registered read data |
| mismatch | output | 1 | Accepted and expected identifiers differ |
| unstable | output | 1 | Long run of changing multiframes |
| in_sync | output | 1 | Multiframe alignment locked |

## Verification
Two pairs of functions can land on the same edge, and the bench provokes both.

- Read versus acceptance. The bench holds `rd_addr` on slot 15 while the third identical multiframe completes. The read is therefore registered on the same edge that overwrites the accepted copy, and `rd_data` must show the pre-acceptance byte for one cycle before the new byte appears.
- Alarm versus completion. The bench raises the loss-of-signal alarm together with the last byte of a locked multiframe. The alarm must win: no acceptance, an all-ones identifier, and `in_sync` dropping.

The behavioural model in the bench judges both cases on every cycle.

// File: rtl/rtt_pkg.sv
`timescale 1ns/1ps
package rtt_pkg;
    localparam int unsigned TT_LEN    = 16;
    localparam int unsigned TT_BYTE_W = 8;
    localparam int unsigned TT_ACCEPT = 3;
    localparam int unsigned TT_UNSTAB = 8;

    typedef enum logic [1:0] {
        ALN_HUNT    = 2'd0,
        ALN_PRESYNC = 2'd1,
        ALN_SYNC    = 2'd2,
        ALN_SLIP    = 2'd3
    } aln_state_e;
endpackage

// File: rtl/rtt_align.sv
`timescale 1ns/1ps
module rtt_align #(
    parameter int unsigned LEN = rtt_pkg::TT_LEN,
    localparam int unsigned AW = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alarm,
    input  logic          sync_en,
    input  logic          vld,
    input  logic          msb,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          mf_done,
    output logic          in_sync
);
    import rtt_pkg::*;

    aln_state_e    st_q, st_d;
    logic [AW-1:0] pos_q, pos_d;
    logic          at_start, at_last;
    logic [AW-1:0] pos_inc;

    assign at_start = (pos_q == '0);
    assign at_last  = (pos_q == AW'(LEN-1));
    assign pos_inc  = at_last ? '0 : pos_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ALN_HUNT;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        if (alarm) begin
            st_d  = ALN_HUNT;
            pos_d = '0;
        end else if (vld) begin
            if (!sync_en) begin
                st_d  = ALN_HUNT;
                pos_d = pos_inc;
            end else begin
                unique case (st_q)
                    ALN_HUNT: begin
                        if (msb) begin
                            st_d  = ALN_PRESYNC;
                            pos_d = pos_inc;
                        end
                    end
                    ALN_PRESYNC: begin
                        if (msb == at_start) begin
                            pos_d = pos_inc;
                            if (at_start) st_d = ALN_SYNC;
                        end else begin
                            st_d  = ALN_HUNT;
                            pos_d = '0;
                        end
                    end
                    ALN_SYNC: begin
                        pos_d = pos_inc;
                        if (at_start && !msb) st_d = ALN_SLIP;
                    end
                    ALN_SLIP: begin
                        if (at_start && !msb) begin
                            st_d  = ALN_HUNT;
                            pos_d = '0;
                        end else begin
                            pos_d = pos_inc;
                            if (at_start) st_d = ALN_SYNC;
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        mf_done = 1'b0;
        wr_idx  = pos_q;
        in_sync = sync_en && ((st_q == ALN_SYNC) || (st_q == ALN_SLIP));
        if (!alarm && vld) begin
            if (!sync_en) begin
                wr_en   = 1'b1;
                mf_done = at_last;
            end else begin
                unique case (st_q)
                    ALN_HUNT:    wr_en = msb;
                    ALN_PRESYNC: wr_en = (msb == at_start);
                    ALN_SYNC: begin
                        wr_en   = 1'b1;
                        mf_done = at_last;
                    end
                    ALN_SLIP: begin
                        wr_en   = !(at_start && !msb);
                        mf_done = at_last;
                    end
                endcase
            end
        end
    end

    // R8
    alarm_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> (st_q == ALN_HUNT && pos_q == '0));

    // R3
    lock_on_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(vld && msb && !alarm));

    // R4
    no_direct_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ALN_SYNC && !alarm && sync_en) |=> (st_q != ALN_HUNT));
endmodule

// File: rtl/rtt_persist.sv
`timescale 1ns/1ps
module rtt_persist #(
    parameter int unsigned LEN          = rtt_pkg::TT_LEN,
    parameter int unsigned BW           = rtt_pkg::TT_BYTE_W,
    parameter int unsigned ACCEPT_RUN   = rtt_pkg::TT_ACCEPT,
    parameter int unsigned UNSTABLE_RUN = rtt_pkg::TT_UNSTAB,
    localparam int unsigned AW = $clog2(LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alarm,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [BW-1:0]          wr_byte,
    input  logic                   mf_done,
    output logic [LEN-1:0][BW-1:0] acc_o,
    output logic                   unstable_o
);
    localparam int unsigned RW = $clog2(ACCEPT_RUN + 1);
    localparam int unsigned DW = $clog2(UNSTABLE_RUN + 1);

    logic [LEN-1:0][BW-1:0] cap_q, last_q, cand;
    logic                   have_q;
    logic [RW-1:0]          run_q, run_inc;
    logic [DW-1:0]          drun_q, drun_inc;
    logic                   same;

    always_comb begin
        cand = cap_q;
        if (wr_en) cand[wr_idx] = wr_byte;
    end

    assign same     = (cand == last_q);
    assign run_inc  = (run_q == RW'(ACCEPT_RUN)) ? run_q : run_q + 1'b1;
    assign drun_inc = (drun_q == DW'(UNSTABLE_RUN)) ? drun_q : drun_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q      <= '0;
            last_q     <= '0;
            acc_o      <= '1;
            have_q     <= 1'b0;
            run_q      <= '0;
            drun_q     <= '0;
            unstable_o <= 1'b0;
        end else if (alarm) begin
            acc_o      <= '1;
            have_q     <= 1'b0;
            run_q      <= '0;
            drun_q     <= '0;
            unstable_o <= 1'b0;
        end else begin
            if (wr_en) cap_q[wr_idx] <= wr_byte;
            if (mf_done) begin
                if (!have_q) begin
                    have_q <= 1'b1;
                    last_q <= cand;
                    run_q  <= RW'(1);
                    drun_q <= '0;
                end else if (same) begin
                    run_q  <= run_inc;
                    drun_q <= '0;
                    if (run_inc >= RW'(ACCEPT_RUN)) begin
                        acc_o      <= cand;
                        unstable_o <= 1'b0;
                    end
                end else begin
                    last_q <= cand;
                    run_q  <= RW'(1);
                    drun_q <= drun_inc;
                    if (drun_inc >= DW'(UNSTABLE_RUN)) unstable_o <= 1'b1;
                end
            end
        end
    end

    // R8
    alarm_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> (acc_o == '1 && !unstable_o));

    // R6
    accept_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(acc_o) && !$past(alarm)) |-> $past(mf_done));

    // R7
    unstable_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unstable_o) |-> $past(mf_done));
endmodule

// File: rtl/rx_trace_extractor.sv
`timescale 1ns/1ps
module rx_trace_extractor #(
    parameter int unsigned LEN          = rtt_pkg::TT_LEN,
    parameter int unsigned BW           = rtt_pkg::TT_BYTE_W,
    parameter int unsigned ACCEPT_RUN   = rtt_pkg::TT_ACCEPT,
    parameter int unsigned UNSTABLE_RUN = rtt_pkg::TT_UNSTAB,
    localparam int unsigned AW = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] line_byte,
    input  logic          line_vld,
    input  logic          sig_loss,
    input  logic          frame_loss,
    input  logic          ais_alarm,
    input  logic          sync_en,
    input  logic          inv_en,
    input  logic          lsb_first,
    input  logic          exp_wr,
    input  logic [AW-1:0] exp_addr,
    input  logic [BW-1:0] exp_data,
    input  logic [AW-1:0] rd_addr,
    output logic [BW-1:0] rd_data,
    output logic          mismatch,
    output logic          unstable,
    output logic          in_sync
);
    logic                   alarm;
    logic [BW-1:0]          pbyte;
    logic                   wr_en, mf_done;
    logic [AW-1:0]          wr_idx;
    logic [LEN-1:0][BW-1:0] acc_id, exp_q;
    logic [BW-1:0]          sel, sel_rev;

    assign alarm = sig_loss | frame_loss | ais_alarm;
    assign pbyte = inv_en ? ~line_byte : line_byte;

    rtt_align #(.LEN(LEN)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .alarm   (alarm),
        .sync_en (sync_en),
        .vld     (line_vld),
        .msb     (pbyte[BW-1]),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .mf_done (mf_done),
        .in_sync (in_sync)
    );

    rtt_persist #(
        .LEN(LEN), .BW(BW), .ACCEPT_RUN(ACCEPT_RUN), .UNSTABLE_RUN(UNSTABLE_RUN)
    ) u_persist (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm      (alarm),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_byte    (pbyte),
        .mf_done    (mf_done),
        .acc_o      (acc_id),
        .unstable_o (unstable)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_q <= '0;
        else if (exp_wr) exp_q[exp_addr] <= exp_data;
    end

    assign sel = acc_id[rd_addr];
    always_comb begin
        for (int i = 0; i < BW; i++) sel_rev[i] = sel[BW-1-i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '1;
        else        rd_data <= lsb_first ? sel_rev : sel;
    end

    assign mismatch = (acc_id != exp_q);

    // R9
    mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(exp_wr) && $stable(acc_id)) |-> $stable(mismatch));
endmodule

// File: tb/rx_trace_extractor_bench.sv
`timescale 1ns/1ps
module rx_trace_extractor_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [7:0] line_byte = 8'hFF;
    logic       line_vld = 1'b0, sig_loss = 1'b0, frame_loss = 1'b0, ais_alarm = 1'b0;
    logic       sync_en = 1'b1, inv_en = 1'b0, lsb_first = 1'b0, exp_wr = 1'b0;
    logic [3:0] exp_addr = '0, rd_addr = '0;
    logic [7:0] exp_data = '0;
    logic [7:0] rd_data;
    logic       mismatch, unstable, in_sync;

    int    n_chk = 0, n_fail = 0;
    string phase = "R1 reset";

    rx_trace_extractor u_rx_trace_extractor (
        .clk(clk), .rst_n(rst_n), .line_byte(line_byte), .line_vld(line_vld),
        .sig_loss(sig_loss), .frame_loss(frame_loss), .ais_alarm(ais_alarm),
        .sync_en(sync_en), .inv_en(inv_en), .lsb_first(lsb_first),
        .exp_wr(exp_wr), .exp_addr(exp_addr), .exp_data(exp_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mismatch(mismatch),
        .unstable(unstable), .in_sync(in_sync)
    );

    // behavioural reference
    logic [15:0][7:0] m_cap, m_last, m_acc, m_exp;
    int   m_st, m_pos, m_run, m_drun;
    bit   m_have, m_unst, live;
    logic [7:0] m_rd;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] b;
        bit mk, wr, done;
        int idx;
        m_rd = lsb_first ? rev8(m_acc[rd_addr]) : m_acc[rd_addr];
        if (exp_wr) m_exp[exp_addr] = exp_data;
        if (sig_loss || frame_loss || ais_alarm) begin
            m_st = 0; m_pos = 0; m_acc = '1; m_have = 0; m_run = 0; m_drun = 0; m_unst = 0;
        end else if (line_vld) begin
            b = inv_en ? ~line_byte : line_byte;
            mk = b[7]; wr = 0; done = 0; idx = m_pos;
            if (!sync_en) begin
                wr = 1; done = (m_pos == 15); m_pos = (m_pos + 1) % 16;
            end else if (m_st == 0) begin
                if (mk) begin wr = 1; idx = 0; m_pos = 1; m_st = 1; end
            end else if (m_st == 1) begin
                if (mk == (m_pos == 0)) begin
                    wr = 1; if (m_pos == 0) m_st = 2; m_pos = (m_pos + 1) % 16;
                end else begin m_st = 0; m_pos = 0; end
            end else begin
                if (m_pos == 0 && !mk && m_st == 3) begin m_st = 0; m_pos = 0; end
                else begin
                    if (m_pos == 0) m_st = mk ? 2 : 3;
                    wr = 1; done = (m_pos == 15); m_pos = (m_pos + 1) % 16;
                end
            end
            if (wr) m_cap[idx] = b;
            if (done) begin
                if (!m_have) begin m_have = 1; m_last = m_cap; m_run = 1; m_drun = 0; end
                else if (m_cap == m_last) begin
                    m_run = (m_run < 3) ? m_run + 1 : 3; m_drun = 0;
                    if (m_run >= 3) begin m_acc = m_cap; m_unst = 0; end
                end else begin
                    m_last = m_cap; m_run = 1;
                    m_drun = (m_drun < 8) ? m_drun + 1 : 8;
                    if (m_drun >= 8) m_unst = 1;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cap = '0; m_last = '0; m_acc = '1; m_exp = '0;
            m_st = 0; m_pos = 0; m_run = 0; m_drun = 0; m_have = 0; m_unst = 0;
            m_rd = 8'hFF; live = 0;
        end else begin
            model_step();
            live = 1;
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n && live) begin
            chk(rd_data, m_rd, "R10 rd_data");
            chk({7'd0, mismatch}, {7'd0, m_acc != m_exp}, "R9 mismatch");
            chk({7'd0, unstable}, {7'd0, m_unst}, "R7 unstable");
            chk({7'd0, in_sync}, {7'd0, sync_en && (m_st >= 2)}, "R3 in_sync");
        end
    end

    // stimulus helpers
    task automatic step(); @(posedge clk); #1; endtask

    task automatic put(input logic [7:0] b);
        line_byte = b; line_vld = 1'b1; step();
        line_vld = 1'b0; line_byte = 8'hFF;
    endtask

    task automatic send_id(input logic [15:0][7:0] id, input bit gap);
        for (int k = 0; k < 16; k++) begin
            put(id[k]);
            if (gap) step();
        end
    endtask

    function automatic logic [15:0][7:0] mk_id(input int seed, input bit mark);
        logic [15:0][7:0] r;
        for (int k = 0; k < 16; k++) r[k] = {1'b0, 7'((seed * 37 + k * 11 + 5) % 128)};
        if (mark) r[0][7] = 1'b1;
        return r;
    endfunction

    task automatic do_reset(input bit s, input bit inv);
        rst_n = 1'b0; sync_en = s; inv_en = inv; lsb_first = 1'b0;
        repeat (3) step();
        rst_n = 1'b1; step();
    endtask

    task automatic read_at(input int a);
        rd_addr = 4'(a); step(); @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    logic [15:0][7:0] ida, idb, idm, idc;

    initial begin
        ida = mk_id(3, 1); idb = mk_id(5, 1); idc = mk_id(9, 0);
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        // R1 reset state
        chk(rd_data, 8'hFF, "R1 rd_data");
        chk({7'd0, mismatch}, 8'd1, "R1 mismatch");
        chk({7'd0, unstable}, 8'd0, "R1 unstable");
        chk({7'd0, in_sync}, 8'd0, "R1 in_sync");
        step();

        phase = "R9 program expected";
        for (int k = 0; k < 16; k++) begin
            exp_wr = 1'b1; exp_addr = 4'(k); exp_data = ida[k]; step();
        end
        exp_wr = 1'b0;

        phase = "R3 R6 lock and accept";
        put(8'h12); put(8'h05);
        send_id(ida, 0); send_id(ida, 0); send_id(ida, 0);
        rd_addr = 4'd15;
        send_id(ida, 1);
        @(negedge clk);
        chk({7'd0, in_sync}, 8'd1, "R3 locked");
        chk({7'd0, mismatch}, 8'd0, "R9 matches expected");
        for (int k = 0; k < 16; k += 5) begin
            read_at(k); chk(rd_data, ida[k], "R6 accepted byte");
        end

        phase = "R10 bit order";
        lsb_first = 1'b1;
        read_at(3); chk(rd_data, rev8(ida[3]), "R10 reversed byte");
        lsb_first = 1'b0;

        phase = "R4 slip handling";
        idm = ida; idm[0][7] = 1'b0; idm[6][7] = 1'b1;
        send_id(idm, 0);
        @(negedge clk); chk({7'd0, in_sync}, 8'd1, "R4 slip keeps lock");
        send_id(ida, 0);
        send_id(idm, 0); send_id(idm, 0);
        @(negedge clk); chk({7'd0, in_sync}, 8'd0, "R4 second miss drops lock");
        read_at(1); chk(rd_data, ida[1], "R4 store kept");

        phase = "R7 unstable";
        for (int s = 20; s < 31; s++) send_id(mk_id(s, 1), 0);
        @(negedge clk); chk({7'd0, unstable}, 8'd1, "R7 raised");
        send_id(idb, 0); send_id(idb, 0); send_id(idb, 0);
        @(negedge clk); chk({7'd0, unstable}, 8'd0, "R7 cleared on accept");
        chk({7'd0, mismatch}, 8'd1, "R9 differs");
        read_at(2); chk(rd_data, idb[2], "R6 second identifier");

        phase = "R8 alarm";
        for (int k = 0; k < 15; k++) put(idb[k]);
        line_byte = idb[15]; line_vld = 1'b1; sig_loss = 1'b1; step();
        line_vld = 1'b0; sig_loss = 1'b0;
        read_at(0); chk(rd_data, 8'hFF, "R8 forced ones");
        chk({7'd0, in_sync}, 8'd0, "R8 lock dropped");
        frame_loss = 1'b1; step(); frame_loss = 1'b0;
        ais_alarm = 1'b1; put(8'h80); ais_alarm = 1'b0;
        send_id(ida, 0); send_id(ida, 0);
        ais_alarm = 1'b1; step(); ais_alarm = 1'b0;
        step();

        phase = "R5 R11 free-running slots";
        do_reset(1'b0, 1'b0);
        send_id(idc, 1); send_id(idc, 1); send_id(idc, 1);
        @(negedge clk);
        read_at(5); chk(rd_data, idc[5], "R5 cyclic accept");
        read_at(0); chk(rd_data, idc[0], "R11 gaps ignored");

        phase = "R2 inversion";
        do_reset(1'b1, 1'b1);
        for (int r = 0; r < 4; r++) send_id(~ida, 0);
        @(negedge clk);
        chk({7'd0, in_sync}, 8'd1, "R2 lock on inverted marker");
        read_at(0); chk(rd_data, ida[0], "R2 inverted accept");
        step();

        finish_run();
    end
endmodule